// File: doc/BRIEF.md
# Periodic and One-Shot Timer Comparator Channel

This block is a single comparator channel of an event timer. It watches a shared 32-bit main counter and emits a one-cycle `fire` strobe when the counter reaches the channel's comparator value. Bus decode and interrupt delivery happen outside it: the surrounding logic hands it register writes and consumes the strobe.

In one-shot mode the comparator is a plain target value. In periodic mode the channel also keeps a period. After each match it moves the comparator ahead by one period. When the counter starts, or when the comparator or period changes while the counter runs, it snaps the comparator forward to the next period boundary after the current count. The channel also owns its mode/capability word. That word holds the mode bits, a self-clearing value-set bit that decides whether a periodic comparator write also moves the comparator, and read-only capability bits.

Top module: `hpt_channel`

## Requirements
- R1: After reset the comparator reads 0xFFFFFFFF, the period is 0, `fire` is low, and the mode word reads 0x00050000 in bits 31:0 with the `PIN_MASK` parameter in bits 63:32.
- R2: Mode word layout: bit 0 periodic, bit 1 value-set, bit 3 irq-enable, bit 4 level, bit 5 message-enable and bits 12:8 route are writable. Bit 2 (force-32) always reads 0. Bit 16 (periodic-capable) reads 1, bit 17 (64-bit-capable) reads 0 and bit 18 (message-capable) reads 1 whatever is written. All other bits of 31:0 read 0, and bits 63:32 always read `PIN_MASK`.
- R3: In periodic mode a comparator write sets the period to the written value. It also loads the comparator only when the value-set bit is 1; otherwise the comparator keeps its value.
- R4: In one-shot mode a comparator write loads the comparator directly, and `cmp_rdata` always returns the comparator value, never the period.
- R5: The value-set bit reads 0 after any comparator write.
- R6: `fire` is high for the one cycle after a clock in which `cnt_en` and `cnt_tick` are 1, no comparator write is in progress, and `cnt_val` equals the comparator. When `cnt_en` is 0 no match is seen.
- R7: In periodic mode with a non-zero period, a match advances the comparator by exactly one period.
- R8: In periodic mode with a non-zero period, the comparator becomes base + ((cnt_val − base) / period + 1) × period, computed in 32-bit wraparound arithmetic. This happens on a rising edge of `cnt_en` (base = the current comparator), and on a comparator write that changes the comparator or the period while `cnt_en` is 1 (base = the comparator that write would load).
- R9: In one-shot mode a comparator value the counter has already passed is left unchanged, so the channel fires only when the counter wraps around and reaches it again.
- R10: Writing the mode word with bit 0 clear sets the period to 0, so a channel later returned to periodic mode without a new period does not advance after a match.
- R11: In periodic mode a period of 0 behaves as one-shot: no reload on a match or on counter start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Main counter is running |
| cnt_tick | input | 1 | Main counter took a new value this cycle |
| cnt_val | input | 32 | Current main counter value |
| cfg_wr | input | 1 | Write strobe for the mode word (bits 31:0) |
| cfg_wdata | input | 32 | Mode word write data |
| cmp_wr | input | 1 | Write strobe for the comparator register |
| cmp_wdata | input | 32 | Comparator register write data |
| cfg_rdata | output | 64 | Mode word and capability read value |
| cmp_rdata | output | 32 | Current comparator value |
| fire | output | 1 | One-cycle match strobe |

## Verification
Two situations are hardest to reach from the ports. The first is a one-shot comparator that lies behind the counter, which only fires after a full 32-bit wrap. The second is the round-up reload when (cnt_val − base) wraps. The bench drives `cnt_val` directly rather than counting from zero. It parks the counter just below 0xFFFFFFFF so that it crosses the wrap in a few dozen ticks. It programs a value-set write with a base far ahead of a small counter, so the wrapped quotient path is taken. Leaving periodic mode is checked at the ports by returning to periodic mode and showing that a later match does not move the comparator.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    localparam int CNT_W   = 32;
    localparam int WORD_W  = 32;
    localparam int ROUTE_W = 5;

    // Mode word bit positions
    localparam int F_PERIODIC = 0;
    localparam int F_VALSET   = 1;
    localparam int F_FORCE32  = 2;
    localparam int F_IRQ_EN   = 3;
    localparam int F_LEVEL    = 4;
    localparam int F_MSG_EN   = 5;
    localparam int F_ROUTE    = 8;
    localparam int F_CAP_PER  = 16;
    localparam int F_CAP_WIDE = 17;
    localparam int F_CAP_MSG  = 18;

    typedef logic [CNT_W-1:0]  tick_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic               periodic;
        logic               valset;
        logic               irq_en;
        logic               level;
        logic               msg_en;
        logic [ROUTE_W-1:0] route;
    } chan_mode_t;

    function automatic chan_mode_t unpack_mode(input word_t w);
        chan_mode_t m;
        m.periodic = w[F_PERIODIC];
        m.valset   = w[F_VALSET];
        m.irq_en   = w[F_IRQ_EN];
        m.level    = w[F_LEVEL];
        m.msg_en   = w[F_MSG_EN];
        m.route    = w[F_ROUTE +: ROUTE_W];
        return m;
    endfunction

    function automatic word_t pack_mode(input chan_mode_t m);
        word_t w;
        w                      = '0;
        w[F_PERIODIC]          = m.periodic;
        w[F_VALSET]            = m.valset;
        w[F_FORCE32]           = 1'b0;
        w[F_IRQ_EN]            = m.irq_en;
        w[F_LEVEL]             = m.level;
        w[F_MSG_EN]            = m.msg_en;
        w[F_ROUTE +: ROUTE_W]  = m.route;
        w[F_CAP_PER]           = 1'b1;
        w[F_CAP_WIDE]          = 1'b0;
        w[F_CAP_MSG]           = 1'b1;
        return w;
    endfunction

    // First period boundary strictly after 'now', on the lattice through 'base'.
    function automatic tick_t next_boundary(input tick_t base, input tick_t now,
                                            input tick_t step);
        tick_t lag;
        tick_t steps;
        if (step == '0) return base;
        lag   = now - base;
        steps = lag / step + tick_t'(1);
        return base + steps * step;
    endfunction

endpackage

// File: rtl/hpt_mode_reg.sv
module hpt_mode_reg
    import hpt_pkg::*;
#(
    parameter logic [WORD_W-1:0] PIN_MASK = 32'h00F0_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  word_t         wdata,
    input  logic          valset_clr,
    output chan_mode_t    mode,
    output logic [2*WORD_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= '0;
        end else if (wr) begin
            mode <= unpack_mode(wdata);
        end else if (valset_clr) begin
            mode.valset <= 1'b0;
        end
    end

    assign rdata = {PIN_MASK, pack_mode(mode)};

    // R5: value-set drops after a comparator write
    assert_valset_selfclear_R5: assert property (@(posedge clk) disable iff (rst)
        (valset_clr && !wr) |=> !mode.valset);

endmodule

// File: rtl/hpt_match.sv
module hpt_match
    import hpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cnt_en,
    input  logic  cnt_tick,
    input  tick_t cnt_val,
    input  tick_t cmp,
    input  logic  hold,
    output logic  hit,
    output logic  fire
);

    assign hit = cnt_en && cnt_tick && !hold && (cnt_val == cmp);

    always_ff @(posedge clk) begin
        if (rst) fire <= 1'b0;
        else     fire <= hit;
    end

    // R6: no strobe unless the counter was running
    assert_fire_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(cnt_en));

endmodule

// File: rtl/hpt_cmp_core.sv
module hpt_cmp_core
    import hpt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  periodic,
    input  logic  valset,
    input  logic  cmp_wr,
    input  tick_t cmp_wdata,
    input  logic  per_clr,
    input  logic  cnt_en,
    input  tick_t cnt_val,
    input  logic  hit,
    output tick_t cmp,
    output tick_t period
);

    logic  en_q;
    logic  en_rise;
    logic  per_live;
    tick_t w_per;
    tick_t w_base;
    logic  w_changed;
    logic  w_round;
    tick_t rl_base;
    tick_t rl_step;
    tick_t rl_next;

    assign en_rise  = cnt_en && !en_q;
    assign per_live = periodic && (period != '0);

    // What a comparator write would load, before any round-up
    always_comb begin
        if (periodic) begin
            w_per  = cmp_wdata;
            w_base = valset ? cmp_wdata : cmp;
        end else begin
            w_per  = period;
            w_base = cmp_wdata;
        end
        w_changed = (w_base != cmp) || (w_per != period);
        w_round   = w_changed && cnt_en && periodic && (w_per != '0);
    end

    // One shared reload datapath for write, match and counter start
    always_comb begin
        if (cmp_wr) begin
            rl_base = w_base;
            rl_step = w_per;
        end else begin
            rl_base = cmp;
            rl_step = period;
        end
        rl_next = next_boundary(rl_base, cnt_val, rl_step);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp    <= '1;
            period <= '0;
            en_q   <= 1'b0;
        end else begin
            en_q <= cnt_en;
            if (cmp_wr) begin
                cmp    <= w_round ? rl_next : w_base;
                period <= w_per;
            end else if ((hit || en_rise) && per_live) begin
                cmp <= rl_next;
            end
            if (per_clr) period <= '0;
        end
    end

    // R10: a one-shot channel holds no period
    assert_oneshot_no_period_R10: assert property (@(posedge clk) disable iff (rst)
        !periodic |-> (period == '0));

    // R4: one-shot write lands in the comparator
    assert_oneshot_load_R4: assert property (@(posedge clk) disable iff (rst)
        (cmp_wr && !periodic) |=> (cmp == $past(cmp_wdata)));

    // R3: periodic write without value-set leaves the comparator alone
    assert_periodic_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_wr && periodic && !valset && !cnt_en) |=> (cmp == $past(cmp)));

    // R7: a periodic match steps one period
    assert_periodic_step_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && !cmp_wr && periodic && (period != '0)) |=>
            (cmp == $past(cmp) + $past(period)));

    // R11: zero period never reloads on a match
    assert_zero_period_static_R11: assert property (@(posedge clk) disable iff (rst)
        (hit && !cmp_wr && (period == '0)) |=> (cmp == $past(cmp)));

endmodule

// File: rtl/hpt_channel.sv
module hpt_channel
    import hpt_pkg::*;
#(
    parameter logic [31:0] PIN_MASK = 32'h00F0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cnt_en,
    input  logic        cnt_tick,
    input  logic [31:0] cnt_val,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        cmp_wr,
    input  logic [31:0] cmp_wdata,
    output logic [63:0] cfg_rdata,
    output logic [31:0] cmp_rdata,
    output logic        fire
);

    chan_mode_t mode;
    tick_t      cmp;
    tick_t      period;
    logic       hit;
    logic       per_clr;

    assign per_clr = cfg_wr && !cfg_wdata[F_PERIODIC];

    hpt_mode_reg #(.PIN_MASK(PIN_MASK)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .wr         (cfg_wr),
        .wdata      (cfg_wdata),
        .valset_clr (cmp_wr),
        .mode       (mode),
        .rdata      (cfg_rdata)
    );

    hpt_match u_match (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .cnt_tick (cnt_tick),
        .cnt_val  (cnt_val),
        .cmp      (cmp),
        .hold     (cmp_wr),
        .hit      (hit),
        .fire     (fire)
    );

    hpt_cmp_core u_core (
        .clk       (clk),
        .rst       (rst),
        .periodic  (mode.periodic),
        .valset    (mode.valset),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .per_clr   (per_clr),
        .cnt_en    (cnt_en),
        .cnt_val   (cnt_val),
        .hit       (hit),
        .cmp       (cmp),
        .period    (period)
    );

    assign cmp_rdata = cmp;

endmodule

// File: tb/hpt_channel_bench.sv
module hpt_channel_bench;

    localparam logic [31:0] MASK = 32'h00F0_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cnt_en;
    logic        cnt_tick;
    logic [31:0] cnt_val;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic        cmp_wr;
    logic [31:0] cmp_wdata;
    logic [63:0] cfg_rdata;
    logic [31:0] cmp_rdata;
    logic        fire;

    always #4 clk = ~clk;

    hpt_channel #(.PIN_MASK(MASK)) u_hpt_channel (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cfg_rdata(cfg_rdata), .cmp_rdata(cmp_rdata), .fire(fire)
    );

    int          checks = 0;
    int          fails  = 0;
    logic        done   = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] last_cnt = '0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic logic [31:0] nb(input logic [31:0] b, input logic [31:0] n,
                                       input logic [31:0] s);
        return b + ((n - b) / s + 32'd1) * s;
    endfunction

    // Monitor: each strobe must match the next expected counter value (R6)
    always @(negedge clk) begin
        if (!rst && fire) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R6 unexpected fire actual=%h expected=none", last_cnt);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check("R6 fire position", {32'd0, last_cnt}, {32'd0, e});
            end
        end
        last_cnt = cnt_val;
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_cfg(input logic [31:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic wr_cmp(input logic [31:0] v);
        cmp_wr = 1'b1; cmp_wdata = v;
        step();
        cmp_wr = 1'b0;
    endtask

    task automatic count(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_val  = cnt_val + 32'd1;
            cnt_tick = 1'b1;
            step();
        end
        cnt_tick = 1'b0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cnt_en = 1'b0; cnt_tick = 1'b0; cnt_val = '0;
        cfg_wr = 1'b0; cfg_wdata = '0; cmp_wr = 1'b0; cmp_wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        step();

        // R1 reset state
        check("R1 comparator", {32'd0, cmp_rdata}, 64'h0000_0000_FFFF_FFFF);
        check("R1 mode word", cfg_rdata, {MASK, 32'h0005_0000});
        check("R1 fire", {63'd0, fire}, 64'd0);

        // R2 layout, read-only and read-as-zero bits
        wr_cfg(32'hFFFF_FFFF);
        check("R2 all ones", cfg_rdata, {MASK, 32'h0005_1F3B});
        wr_cfg(32'h0000_0000);
        check("R2 all zeros", cfg_rdata, {MASK, 32'h0005_0000});

        // R4/R5 one-shot write
        wr_cfg(32'h0000_0002);
        wr_cmp(32'h40);
        check("R4 one-shot load", {32'd0, cmp_rdata}, 64'h40);
        check("R5 value-set cleared", cfg_rdata, {MASK, 32'h0005_0000});

        // R6 one-shot match
        cnt_val = 32'h30; cnt_en = 1'b1;
        step();
        exp_q.push_back(32'h40);
        count(32'h20);
        check("R9 one-shot no reload", {32'd0, cmp_rdata}, 64'h40);

        // R9 past value: silent until wrap
        count(32'h20);
        cnt_val = 32'hFFFF_FFF8;
        step();
        exp_q.push_back(32'h40);
        count(32'h50);
        check("R9 fired after wrap", exp_q.size(), 0);

        // R6 disabled counter does not match
        cnt_en = 1'b0; cnt_val = 32'h3C;
        step();
        count(8);
        check("R6 disabled no match", exp_q.size(), 0);

        // R3 periodic writes
        wr_cfg(32'h0000_0003);
        wr_cmp(32'd500);
        check("R3 value-set load", {32'd0, cmp_rdata}, 64'd500);
        wr_cmp(32'd100);
        check("R3 period-only write", {32'd0, cmp_rdata}, 64'd500);
        check("R5 value-set cleared periodic", cfg_rdata, {MASK, 32'h0005_0001});

        // R8 counter start round-up
        cnt_val = 32'd700; cnt_en = 1'b1;
        step();
        check("R8 start round-up", {32'd0, cmp_rdata}, {32'd0, nb(32'd500, 32'd700, 32'd100)});

        // R7 periodic fires
        exp_q.push_back(32'd800);
        exp_q.push_back(32'd900);
        count(250);
        check("R7 advanced by period", {32'd0, cmp_rdata}, 64'd1000);

        // R8 write while running, plain and wrapped
        wr_cfg(32'h0000_0003);
        wr_cmp(32'd7);
        check("R8 write round-up", {32'd0, cmp_rdata}, {32'd0, nb(32'd7, 32'd950, 32'd7)});
        cnt_val = 32'd10;
        step();
        wr_cfg(32'h0000_0003);
        wr_cmp(32'd1000);
        check("R8 wrapped round-up", {32'd0, cmp_rdata}, {32'd0, nb(32'd1000, 32'd10, 32'd1000)});

        // R11 zero period in periodic mode
        cnt_en = 1'b0;
        step();
        wr_cfg(32'h0000_0003);
        wr_cmp(32'h300);
        wr_cfg(32'h0000_0001);
        wr_cmp(32'h0);
        check("R11 zero period write", {32'd0, cmp_rdata}, 64'h300);
        cnt_val = 32'h2F0; cnt_en = 1'b1;
        step();
        check("R11 no start reload", {32'd0, cmp_rdata}, 64'h300);
        exp_q.push_back(32'h300);
        count(32'h20);
        check("R11 no match reload", {32'd0, cmp_rdata}, 64'h300);

        // R10 leaving periodic drops the period
        cnt_en = 1'b0;
        step();
        wr_cfg(32'h0000_0003);
        wr_cmp(32'h400);
        wr_cfg(32'h0000_0000);
        wr_cfg(32'h0000_0001);
        cnt_val = 32'h3F0; cnt_en = 1'b1;
        step();
        exp_q.push_back(32'h400);
        count(32'h20);
        check("R10 period cleared", {32'd0, cmp_rdata}, 64'h400);

        step();
        step();
        check("R6 all fires seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule